// File: doc/BRIEF.md
# SD SPI Command Frame Builder

This block produces the six-byte command token that a host sends to a memory card in SPI mode. A single-cycle `start_i` pulse captures a 6-bit command index and a 32-bit argument. The block then runs a bit-serial CRC7 over the 40 header bits, which takes one clock per bit. After that it presents the frame one byte at a time to a downstream SPI shifter through a valid/ready handshake. Every command carries a correct CRC and an end bit of 1, so cards that check CRC in SPI mode accept any command, including the application-specific ones. When the last byte has been accepted, `done_o` pulses for one cycle.

The controller has four named states:

| State | What it does | Transition out |
|-------|--------------|----------------|
| `ST_IDLE` | Waits for a start pulse | `start_i` → `ST_CRC`. This is the capture transition: the command, the argument and a cleared CRC are loaded. |
| `ST_CRC` | Feeds one header bit per cycle into the CRC | After the 40th bit → `ST_SEND` |
| `ST_SEND` | Holds `byte_valid_o` high | A handshake on any byte before the last → stays in `ST_SEND` and advances. A handshake on the last byte → `ST_DONE`. |
| `ST_DONE` | Raises `done_o` for one cycle | Always → `ST_IDLE` |

Top module: `sdcf_cmd_framer`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o`, `byte_valid_o` and `done_o` are all 0.
- R2: The first byte sent is `{1'b0, 1'b1, cmd[5:0]}`. The next four bytes are the argument, most significant byte first: arg[31:24], arg[23:16], arg[15:8], arg[7:0].
- R3: The sixth byte is `{crc7[6:0], 1'b1}`. The CRC uses the polynomial x^7+x^3+1 with an initial value of 0. It is computed MSB first over the 40 bits made of the first five bytes. Example: command 0 with argument 0 gives 0x95.
- R4: Bit 0 of the sixth byte is always 1, for every command and argument. Example: command 8 with argument 0x000001AA gives 0x87.
- R5: If `start_i` is sampled high in `ST_IDLE` at clock edge k, then `busy_o` is 1 from edge k onward. The first byte becomes valid exactly after edge k+40.
- R6: While `byte_valid_o` is 1 and `byte_ready_i` is 0, the byte and the valid flag hold unchanged. The frame advances by one byte only on a cycle where both are 1.
- R7: `done_o` is high for exactly one cycle, namely the cycle after the sixth byte is accepted. The block is then idle.
- R8: A `start_i` pulse while `busy_o` or `done_o` is 1 is ignored. Input changes after capture do not alter the frame being sent.
- R9: Correct CRC bytes are produced for every command, not only the two boot commands. Examples: command 55 with argument 0 gives a last byte of 0x65, and command 41 with argument 0x40000000 gives 0x77.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| cmd_i | input | 6 | Command index |
| arg_i | input | 32 | Command argument |
| byte_ready_i | input | 1 | Downstream shifter accepts the current byte |
| byte_o | output | 8 | Current frame byte |
| byte_valid_o | output | 1 | `byte_o` holds a frame byte |
| busy_o | output | 1 | A frame is being built or sent |
| done_o | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The embedded assertions check the following on every cycle:
- the handshake hold rule;
- the single-cycle done pulse and the return to idle;
- the end bit and the start/transmit bits at the frame edges;
- that valid never rises except out of the CRC phase.

Only the bench scenarios can show the frame contents themselves. These are the argument byte order, the CRC values for the boot and application commands, the exact 40-cycle latency, and the fact that starts arriving mid-frame are ignored. For this the bench compares the outputs against a behavioural model on every clock, under stalling and random ready patterns.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
    localparam int CMD_W       = 6;
    localparam int ARG_W       = 32;
    localparam int CRC_W       = 7;
    localparam int HDR_BITS    = 2 + CMD_W + ARG_W;
    localparam int FRAME_BITS  = HDR_BITS + CRC_W + 1;
    localparam int FRAME_BYTES = FRAME_BITS / 8;
    localparam int BIT_CW      = $clog2(HDR_BITS);
    localparam int BYTE_CW     = $clog2(FRAME_BYTES);
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CRC,
        ST_SEND,
        ST_DONE
    } sdcf_state_e;
endpackage

// File: rtl/sdcf_crc7.sv
module sdcf_crc7
    import sdcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] crc_q;
    logic             fb;

    assign fb = crc_q[CRC_W-1] ^ bit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr_i) begin
            crc_q <= '0;
        end else if (en_i) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
    end

    assign crc_o = crc_q;

    // R3: the register only moves while the CRC phase feeds it
    a_r3_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(crc_q));
endmodule

// File: rtl/sdcf_ctrl.sv
module sdcf_ctrl
    import sdcf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               ready_i,
    output logic               capture_o,
    output logic               crc_en_o,
    output logic [BIT_CW-1:0]  bit_sel_o,
    output logic [BYTE_CW-1:0] byte_sel_o,
    output logic               first_o,
    output logic               last_o,
    output logic               valid_o,
    output logic               busy_o,
    output logic               done_o
);
    sdcf_state_e state_q, state_d;
    logic [BIT_CW-1:0]  bit_cnt_q;
    logic [BYTE_CW-1:0] byte_cnt_q;
    logic               bits_end;
    logic               byte_last;

    assign bits_end  = (bit_cnt_q == BIT_CW'(HDR_BITS - 1));
    assign byte_last = (byte_cnt_q == BYTE_CW'(FRAME_BYTES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)              state_d = ST_CRC;
            ST_CRC:  if (bits_end)             state_d = ST_SEND;
            ST_SEND: if (ready_i && byte_last) state_d = ST_DONE;
            ST_DONE:                           state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt_q  <= '0;
                    byte_cnt_q <= '0;
                end
                ST_CRC: begin
                    if (!bits_end) bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                ST_SEND: begin
                    if (ready_i && !byte_last) byte_cnt_q <= byte_cnt_q + 1'b1;
                end
                ST_DONE: begin
                    byte_cnt_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        capture_o = 1'b0;
        crc_en_o  = 1'b0;
        valid_o   = 1'b0;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: capture_o = start_i;
            ST_CRC: begin
                crc_en_o = 1'b1;
                busy_o   = 1'b1;
            end
            ST_SEND: begin
                valid_o = 1'b1;
                busy_o  = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign bit_sel_o  = bit_cnt_q;
    assign byte_sel_o = byte_cnt_q;
    assign first_o    = (byte_cnt_q == '0);
    assign last_o     = byte_last;

    // R5: the send phase is entered only out of the CRC phase
    a_r5_send_after_crc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(state_q) == ST_CRC);
    // R7: done lasts one cycle and is followed by idle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o && !valid_o));
    // R8: capture never happens during a frame
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || done_o) |-> !capture_o);
endmodule

// File: rtl/sdcf_byte_mux.sv
module sdcf_byte_mux
    import sdcf_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic [BYTE_CW-1:0]    sel_i,
    output logic [7:0]            byte_o
);
    logic [7:0] lane [FRAME_BYTES];

    for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_lane
        assign lane[g] = frame_i[(FRAME_BYTES - 1 - g) * 8 +: 8];
    end

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < FRAME_BYTES; i++) begin
            if (sel_i == BYTE_CW'(i)) byte_o = lane[i];
        end
    end
endmodule

// File: rtl/sdcf_cmd_framer.sv
module sdcf_cmd_framer
    import sdcf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [5:0]  cmd_i,
    input  logic [31:0] arg_i,
    input  logic        byte_ready_i,
    output logic [7:0]  byte_o,
    output logic        byte_valid_o,
    output logic        busy_o,
    output logic        done_o
);
    logic [HDR_BITS-1:0]   hdr_q;
    logic                  capture;
    logic                  crc_en;
    logic [BIT_CW-1:0]     bit_sel;
    logic [BYTE_CW-1:0]    byte_sel;
    logic                  first_byte;
    logic                  last_byte;
    logic [CRC_W-1:0]      crc;
    logic [BIT_CW-1:0]     hdr_idx;
    logic                  hdr_bit;
    logic [FRAME_BITS-1:0] frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
        end else if (capture) begin
            hdr_q <= {2'b01, cmd_i, arg_i};
        end
    end

    assign hdr_idx = BIT_CW'(HDR_BITS - 1) - bit_sel;
    assign hdr_bit = hdr_q[hdr_idx];
    assign frame   = {hdr_q, crc, 1'b1};

    sdcf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ready_i    (byte_ready_i),
        .capture_o  (capture),
        .crc_en_o   (crc_en),
        .bit_sel_o  (bit_sel),
        .byte_sel_o (byte_sel),
        .first_o    (first_byte),
        .last_o     (last_byte),
        .valid_o    (byte_valid_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    sdcf_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (capture),
        .en_i  (crc_en),
        .bit_i (hdr_bit),
        .crc_o (crc)
    );

    sdcf_byte_mux u_mux (
        .frame_i (frame),
        .sel_i   (byte_sel),
        .byte_o  (byte_o)
    );

    // R6: a stalled byte is held
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_o)));
    // R4: end bit of the closing byte
    a_r4_end_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && last_byte) |-> byte_o[0]);
    // R2: start and transmit bits of the opening byte
    a_r2_head_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && first_byte) |-> byte_o[7:6] == 2'b01);
    // R1: nothing is offered while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !byte_valid_o);
endmodule

// File: tb/sdcf_cmd_framer_bench.sv
module sdcf_cmd_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  cmd_i = '0;
    logic [31:0] arg_i = '0;
    logic        byte_ready_i = 1'b0;
    logic [7:0]  byte_o;
    logic        byte_valid_o;
    logic        busy_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ready_mode = 0;

    always #2 clk = ~clk;

    sdcf_cmd_framer u_sdcf_cmd_framer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .arg_i(arg_i), .byte_ready_i(byte_ready_i), .byte_o(byte_o),
        .byte_valid_o(byte_valid_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [7:0] crc_byte(input logic [7:0] hdr [5]);
        int c = 0;
        for (int b = 0; b < 5; b++) begin
            for (int k = 7; k >= 0; k--) begin
                int top = (c / 64) % 2;
                int inb = hdr[b][k];
                c = (c * 2) % 128;
                if (top != inb) c = c ^ 9;
            end
        end
        return 8'((c * 2) + 1);
    endfunction

    // reference model
    int         m_phase = 0;
    int         m_cnt = 0;
    int         m_idx = 0;
    logic [7:0] m_q [6];
    logic [7:0] got [$];

    always @(posedge clk) begin
        if (byte_valid_o && byte_ready_i) got.push_back(byte_o);
        if (!rst_n) begin
            m_phase <= 0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                    logic [7:0] h [5];
                    h[0] = {2'b01, cmd_i};
                    h[1] = arg_i[31:24];
                    h[2] = arg_i[23:16];
                    h[3] = arg_i[15:8];
                    h[4] = arg_i[7:0];
                    for (int i = 0; i < 5; i++) m_q[i] <= h[i];
                    m_q[5] <= crc_byte(h);
                    m_phase <= 1;
                    m_cnt <= 0;
                end
                1: if (m_cnt == 39) begin
                    m_phase <= 2;
                    m_idx <= 0;
                end else m_cnt <= m_cnt + 1;
                2: if (byte_ready_i) begin
                    if (m_idx == 5) m_phase <= 3;
                    else m_idx <= m_idx + 1;
                end
                default: m_phase <= 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare against the model on every clock (R5 timing, R6 hold, R7 pulse, R2/R3 bytes)
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy_o == (m_phase == 1 || m_phase == 2), "R5", "busy", busy_o, 0);
            check(byte_valid_o == (m_phase == 2), "R6", "valid", byte_valid_o, m_phase == 2);
            check(done_o == (m_phase == 3), "R7", "done", done_o, m_phase == 3);
            if (m_phase == 2)
                check(byte_o == m_q[m_idx], "R2", "byte", byte_o, m_q[m_idx]);
        end
    end

    always @(negedge clk) begin
        case (ready_mode)
            0: byte_ready_i <= 1'b1;
            1: byte_ready_i <= ~byte_ready_i;
            2: byte_ready_i <= 1'($urandom % 2);
            default: byte_ready_i <= 1'b0;
        endcase
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic run_cmd(input logic [5:0] c, input logic [31:0] a, input int mode,
                           input int exp_last, input bit poke_busy);
        ready_mode = mode;
        got.delete();
        @(negedge clk);
        cmd_i = c; arg_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R8: change inputs and pulse start mid-frame
        cmd_i = ~c; arg_i = ~a;
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        if (poke_busy) begin
            start_i = 1'b1;   // R8: start during done is ignored
            @(negedge clk);
            start_i = 1'b0;
            check(!busy_o, "R8", "start in done ignored", busy_o, 0);
        end else @(negedge clk);
        check(got.size() == 6, "R7", "byte count", got.size(), 6);
        if (got.size() == 6) begin
            check(got[0] == {2'b01, c}, "R2", "cmd byte", got[0], {2'b01, c});
            check({got[1], got[2], got[3], got[4]} == a, "R2", "arg bytes",
                  {got[1], got[2], got[3], got[4]}, a);
            check(got[5][0] == 1'b1, "R4", "end bit", got[5], 1);
            if (exp_last >= 0)
                check(got[5] == 8'(exp_last), "R3", "crc byte", got[5], exp_last);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !byte_valid_o && !done_o, "R1", "in reset",
              {busy_o, byte_valid_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !byte_valid_o && !done_o, "R1", "after reset",
              {busy_o, byte_valid_o, done_o}, 0);
        run_cmd(6'd0,  32'h0000_0000, 0, 'h95, 1'b0);  // R3
        run_cmd(6'd8,  32'h0000_01AA, 1, 'h87, 1'b0);  // R4
        run_cmd(6'd55, 32'h0000_0000, 2, 'h65, 1'b1);  // R9
        run_cmd(6'd41, 32'h4000_0000, 2, 'h77, 1'b1);  // R9
        run_cmd(6'd63, 32'hFFFF_FFFF, 1, -1, 1'b0);
        run_cmd(6'd17, 32'h1234_5678, 2, -1, 1'b1);
        for (int n = 0; n < 6; n++)
            run_cmd(6'($urandom), $urandom, 2, -1, 1'b0);
        finish_run();
    end
endmodule